// File: doc/BRIEF.md
# DMA Request Issuer with Shared ID Credits

This block sits on the device side of a bridge. It takes client requests (full write, partial write, read, shared read or interrupt) and turns each one into a command toward the memory side. The command carries a 4-bit command code, an address and a 16-bit tag. Writes also send one 128-bit data beat with a byte mask and odd parity. Every command takes a transaction ID from a single pool of 16. The ID stays held until the matching retirement arrives. A write retires through an acknowledge pulse. A read or interrupt retires through a return command whose tag holds the ID.

The client handshake is a valid/ready pair. Ready drops when no ID is free. For an interrupt request it also drops when four interrupts are already outstanding. A return that names an ID which is not outstanding, or which is held by a different kind of transaction, sets a sticky error flag and frees nothing.

Top module: `dma_issuer`

## Requirements
- R1: A request is accepted on a rising edge where req_valid and req_ready are both high. The next cycle, cmd_valid is high for exactly one cycle per accepted request, and cmd_code equals the request kind: 0 full write, 1 partial write, 2 read, 3 shared read, 4 interrupt. cmd_addr equals the request address.
- R2: cmd_tag[14:11] holds the allocated ID. cmd_tag[15] is 1 only for a shared read. All other tag bits are 0.
- R3: Each command takes the lowest-numbered free ID. An ID is not issued again until it has retired.
- R4: With all 16 IDs outstanding, req_ready is low for every kind. A retirement raises it again from the next cycle.
- R5: With 4 interrupts outstanding, req_ready is low for kind 4 but stays high for the other kinds while IDs are free.
- R6: A write (kind 0 or 1) retires when wack_valid pulses with wack_id equal to its ID.
- R7: A read (kind 2 or 3) retires on ret_valid with ret_code 0 or 1 and ret_tag[14:11] equal to its ID. An interrupt retires on ret_code 2 or 3.
- R8: One cycle after a write command, dat_valid is high for one cycle. It carries the request's data in dat_beat and its byte mask in dat_mask. Reads and interrupts produce no data beat.
- R9: Parity is odd. dat_par[k+1] covers dat_beat bits [32k+31:32k] for k = 0..3, and dat_par[0] covers dat_mask.
- R10: An acknowledge or return naming a free ID, or an ID held by another kind, sets err_flag from the next cycle. The flag stays set until reset, and the ID remains outstanding.
- R11: Request kinds 5, 6 and 7 are never accepted: req_ready is low and no command is issued.
- R12: After synchronous reset, req_ready is high, cmd_valid and dat_valid are low, err_flag is low and all IDs are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request present |
| req_kind | input | 3 | Request kind (0..4 valid) |
| req_addr | input | 40 | Request address |
| req_data | input | 128 | Write data beat |
| req_mask | input | 16 | Write byte mask |
| req_ready | output | 1 | Request can be accepted |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 4 | Command code |
| cmd_addr | output | 40 | Command address |
| cmd_tag | output | 16 | Command tag with ID in [14:11] |
| dat_valid | output | 1 | Write data beat strobe |
| dat_beat | output | 128 | Write data |
| dat_mask | output | 16 | Write byte mask |
| dat_par | output | 5 | Odd parity for four lanes and the mask |
| wack_valid | input | 1 | Write acknowledge pulse |
| wack_id | input | 4 | Acknowledged ID |
| ret_valid | input | 1 | Read/interrupt return strobe |
| ret_code | input | 2 | 0/1 read return, 2/3 interrupt return |
| ret_tag | input | 16 | Return tag, ID in [14:11] |
| err_flag | output | 1 | Sticky mismatched-return flag |

## Verification
An ID allocation and a retirement can land on the same clock edge. The bench provokes this by presenting a read request in the same cycle as the return of another outstanding read. The new command must carry the lowest ID that was free before that edge, never the one being retired. The retired ID must then be the one handed to the next request, and the error flag must stay clear. A second collision, between an interrupt retirement and the interrupt cap, is judged by probing ready for kind 4 before and after the retiring return.

// File: rtl/dma_issuer_pkg.sv
package dma_issuer_pkg;

  typedef enum logic [1:0] {
    CLS_WR = 2'd0,
    CLS_RD = 2'd1,
    CLS_IN = 2'd2
  } txn_cls_e;

  localparam logic [2:0] KIND_FULL_WR = 3'd0;
  localparam logic [2:0] KIND_PART_WR = 3'd1;
  localparam logic [2:0] KIND_READ    = 3'd2;
  localparam logic [2:0] KIND_SH_READ = 3'd3;
  localparam logic [2:0] KIND_INTR    = 3'd4;

  function automatic txn_cls_e kind_to_cls(input logic [2:0] kind);
    if (kind == KIND_INTR)
      return CLS_IN;
    else if (kind[1])
      return CLS_RD;
    else
      return CLS_WR;
  endfunction

endpackage

// File: rtl/dma_id_pool.sv
module dma_id_pool
  import dma_issuer_pkg::*;
#(
  parameter int NUM_IDS  = 16,
  parameter int INTR_CAP = 4,
  localparam int ID_W    = $clog2(NUM_IDS),
  localparam int CNT_W   = $clog2(INTR_CAP + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc,
  input  txn_cls_e        alloc_cls,
  input  logic            wack_valid,
  input  logic [ID_W-1:0] wack_id,
  input  logic            ret_valid,
  input  txn_cls_e        ret_cls,
  input  logic [ID_W-1:0] ret_id,
  output logic [ID_W-1:0] pick_id,
  output logic            any_free,
  output logic            intr_full,
  output logic            err_flag
);

  logic [NUM_IDS-1:0] free_q;
  txn_cls_e           owner_q [NUM_IDS];
  logic [CNT_W-1:0]   icnt_q;
  logic               err_q;

  logic wack_hit, ret_hit, bad_ret;

  // lowest free index wins
  always_comb begin
    pick_id = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--)
      if (free_q[i]) pick_id = ID_W'(i);
  end

  assign any_free  = |free_q;
  assign intr_full = (icnt_q == CNT_W'(INTR_CAP));

  assign wack_hit = wack_valid && !free_q[wack_id] && (owner_q[wack_id] == CLS_WR);
  assign ret_hit  = ret_valid  && !free_q[ret_id]  && (owner_q[ret_id]  == ret_cls);
  assign bad_ret  = (wack_valid && !wack_hit) || (ret_valid && !ret_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= '1;
      icnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      logic [NUM_IDS-1:0] nxt;
      nxt = free_q;
      if (alloc)    nxt[pick_id] = 1'b0;
      if (wack_hit) nxt[wack_id] = 1'b1;
      if (ret_hit)  nxt[ret_id]  = 1'b1;
      free_q <= nxt;
      icnt_q <= icnt_q + CNT_W'(alloc && alloc_cls == CLS_IN)
                       - CNT_W'(ret_hit && ret_cls == CLS_IN);
      err_q  <= err_q | bad_ret;
    end
  end

  // owner table needs no reset: only read while the ID is held
  always_ff @(posedge clk) begin
    if (alloc) owner_q[pick_id] <= alloc_cls;
  end

  assign err_flag = err_q;

endmodule

// File: rtl/dma_cmd_stage.sv
module dma_cmd_stage
  import dma_issuer_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int DATA_W  = 128,
  parameter int ID_W    = 4,
  parameter int ID_LSB  = 11,
  parameter int TAG_W   = 16,
  localparam int MASK_W = DATA_W / 8,
  localparam int LANES  = DATA_W / 32,
  localparam int PAR_W  = LANES + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [2:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [MASK_W-1:0] mask,
  input  logic [ID_W-1:0]   id,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [TAG_W-1:0]  cmd_tag,
  output logic              dat_valid,
  output logic [DATA_W-1:0] dat_beat,
  output logic [MASK_W-1:0] dat_mask,
  output logic [PAR_W-1:0]  dat_par
);

  logic              is_wr;
  logic [TAG_W-1:0]  tag_d;
  logic [PAR_W-1:0]  par_d;
  logic              cmd_valid_q, wr_pend_q, dat_valid_q;
  logic [3:0]        code_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] dbuf_q, beat_q;
  logic [MASK_W-1:0] mbuf_q, mask_q;
  logic [PAR_W-1:0]  par_q;

  assign is_wr = (kind_to_cls(kind) == CLS_WR);

  always_comb begin
    tag_d = '0;
    tag_d[ID_LSB +: ID_W] = id;
    tag_d[TAG_W-1]        = (kind == KIND_SH_READ);
  end

  // odd parity: one bit per 32-bit lane above the mask bit
  for (genvar l = 0; l < LANES; l++) begin : g_lane_par
    assign par_d[l+1] = ~^dbuf_q[l*32 +: 32];
  end
  assign par_d[0] = ~^mbuf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid_q <= 1'b0;
      wr_pend_q   <= 1'b0;
      dat_valid_q <= 1'b0;
    end else begin
      cmd_valid_q <= accept;
      wr_pend_q   <= accept && is_wr;
      dat_valid_q <= wr_pend_q;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      code_q <= {1'b0, kind};
      addr_q <= addr;
      tag_q  <= tag_d;
    end
    if (accept && is_wr) begin
      dbuf_q <= data;
      mbuf_q <= mask;
    end
    if (wr_pend_q) begin
      beat_q <= dbuf_q;
      mask_q <= mbuf_q;
      par_q  <= par_d;
    end
  end

  assign cmd_valid = cmd_valid_q;
  assign cmd_code  = code_q;
  assign cmd_addr  = addr_q;
  assign cmd_tag   = tag_q;
  assign dat_valid = dat_valid_q;
  assign dat_beat  = beat_q;
  assign dat_mask  = mask_q;
  assign dat_par   = par_q;

endmodule

// File: rtl/dma_issuer.sv
module dma_issuer
  import dma_issuer_pkg::*;
#(
  parameter int NUM_IDS  = 16,
  parameter int INTR_CAP = 4,
  parameter int ADDR_W   = 40,
  parameter int DATA_W   = 128,
  parameter int ID_LSB   = 11,
  localparam int ID_W    = $clog2(NUM_IDS),
  localparam int MASK_W  = DATA_W / 8,
  localparam int PAR_W   = DATA_W / 32 + 1,
  localparam int TAG_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [MASK_W-1:0] req_mask,
  output logic              req_ready,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [TAG_W-1:0]  cmd_tag,
  output logic              dat_valid,
  output logic [DATA_W-1:0] dat_beat,
  output logic [MASK_W-1:0] dat_mask,
  output logic [PAR_W-1:0]  dat_par,
  input  logic              wack_valid,
  input  logic [ID_W-1:0]   wack_id,
  input  logic              ret_valid,
  input  logic [1:0]        ret_code,
  input  logic [TAG_W-1:0]  ret_tag,
  output logic              err_flag
);

  logic [ID_W-1:0] pick_id;
  logic            any_free, intr_full, accept, kind_ok;
  txn_cls_e        ret_cls;
  logic            unused_tag_bits;

  assign kind_ok   = (req_kind <= KIND_INTR);
  assign req_ready = kind_ok && any_free && !(req_kind == KIND_INTR && intr_full);
  assign accept    = req_valid && req_ready;
  assign ret_cls   = ret_code[1] ? CLS_IN : CLS_RD;
  assign unused_tag_bits = ^{ret_tag[TAG_W-1:ID_LSB+ID_W], ret_tag[ID_LSB-1:0]};

  dma_id_pool #(
    .NUM_IDS  (NUM_IDS),
    .INTR_CAP (INTR_CAP)
  ) u_pool (
    .clk        (clk),
    .rst        (rst),
    .alloc      (accept),
    .alloc_cls  (kind_to_cls(req_kind)),
    .wack_valid (wack_valid),
    .wack_id    (wack_id),
    .ret_valid  (ret_valid),
    .ret_cls    (ret_cls),
    .ret_id     (ret_tag[ID_LSB +: ID_W]),
    .pick_id    (pick_id),
    .any_free   (any_free),
    .intr_full  (intr_full),
    .err_flag   (err_flag)
  );

  dma_cmd_stage #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .ID_LSB (ID_LSB),
    .TAG_W  (TAG_W)
  ) u_stage (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .kind      (req_kind),
    .addr      (req_addr),
    .data      (req_data),
    .mask      (req_mask),
    .id        (pick_id),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_addr  (cmd_addr),
    .cmd_tag   (cmd_tag),
    .dat_valid (dat_valid),
    .dat_beat  (dat_beat),
    .dat_mask  (dat_mask),
    .dat_par   (dat_par)
  );

endmodule

// File: rtl/dma_issuer_chk.sv
module dma_issuer_chk #(
  parameter int NUM_IDS  = 16,
  parameter int INTR_CAP = 4,
  parameter int DATA_W   = 128,
  parameter int ID_LSB   = 11,
  localparam int ID_W    = $clog2(NUM_IDS),
  localparam int MASK_W  = DATA_W / 8,
  localparam int LANES   = DATA_W / 32,
  localparam int PAR_W   = LANES + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        req_kind,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic [3:0]        cmd_code,
  input logic [15:0]       cmd_tag,
  input logic              dat_valid,
  input logic [DATA_W-1:0] dat_beat,
  input logic [MASK_W-1:0] dat_mask,
  input logic [PAR_W-1:0]  dat_par,
  input logic              wack_valid,
  input logic [ID_W-1:0]   wack_id,
  input logic              ret_valid,
  input logic [1:0]        ret_code,
  input logic [15:0]       ret_tag,
  input logic              err_flag
);

  // shadow of outstanding IDs, built from port traffic only
  logic [NUM_IDS-1:0] held_q;
  logic [1:0]         own_q [NUM_IDS];
  int                 icnt_q;
  logic               par_ok;
  logic [ID_W-1:0]    c_id, r_id;
  logic [1:0]         c_cls, r_cls;

  assign c_id  = cmd_tag[ID_LSB +: ID_W];
  assign r_id  = ret_tag[ID_LSB +: ID_W];
  assign c_cls = (cmd_code == 4'd4) ? 2'd2 : (cmd_code[1] ? 2'd1 : 2'd0);
  assign r_cls = ret_code[1] ? 2'd2 : 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      icnt_q <= 0;
    end else begin
      logic [NUM_IDS-1:0] n;
      int                 c;
      n = held_q;
      c = icnt_q;
      if (cmd_valid) begin
        n[c_id] = 1'b1;
        own_q[c_id] <= c_cls;
        if (c_cls == 2'd2) c = c + 1;
      end
      if (wack_valid && held_q[wack_id] && own_q[wack_id] == 2'd0) n[wack_id] = 1'b0;
      if (ret_valid && held_q[r_id] && own_q[r_id] == r_cls) begin
        n[r_id] = 1'b0;
        if (r_cls == 2'd2) c = c - 1;
      end
      held_q <= n;
      icnt_q <= c;
    end
  end

  always_comb begin
    par_ok = (^{dat_par[0], dat_mask}) == 1'b1;
    for (int l = 0; l < LANES; l++)
      if ((^{dat_par[l+1], dat_beat[l*32 +: 32]}) != 1'b1) par_ok = 1'b0;
  end

  AST_SHARED_TAG_BIT: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_tag[15] == (cmd_code == 4'd3))); // R2
  AST_ID_NOT_REUSED: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !held_q[c_id]); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    $countones(held_q) <= NUM_IDS && !(cmd_valid && held_q == '1)); // R4
  AST_INTR_CAP: assert property (@(posedge clk) disable iff (rst)
    icnt_q <= INTR_CAP); // R5
  AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code[3:1] == 3'd0) |=> dat_valid); // R8
  AST_NO_STRAY_DATA: assert property (@(posedge clk) disable iff (rst)
    dat_valid |-> $past(cmd_valid && cmd_code[3:1] == 3'd0)); // R8
  AST_ODD_PARITY: assert property (@(posedge clk) disable iff (rst)
    dat_valid |-> par_ok); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R10
  AST_BAD_KIND_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (req_kind > 3'd4) |-> !req_ready); // R11

endmodule

bind dma_issuer dma_issuer_chk #(
  .NUM_IDS  (NUM_IDS),
  .INTR_CAP (INTR_CAP),
  .DATA_W   (DATA_W),
  .ID_LSB   (ID_LSB)
) u_chk (.*);

// File: tb/dma_issuer_tb.sv
`timescale 1ns/1ps
module dma_issuer_tb;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic [2:0]   req_kind;
  logic [39:0]  req_addr;
  logic [127:0] req_data;
  logic [15:0]  req_mask;
  logic         req_ready;
  logic         cmd_valid;
  logic [3:0]   cmd_code;
  logic [39:0]  cmd_addr;
  logic [15:0]  cmd_tag;
  logic         dat_valid;
  logic [127:0] dat_beat;
  logic [15:0]  dat_mask;
  logic [4:0]   dat_par;
  logic         wack_valid;
  logic [3:0]   wack_id;
  logic         ret_valid;
  logic [1:0]   ret_code;
  logic [15:0]  ret_tag;
  logic         err_flag;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;
  bit  busy [16];
  int  own [16];   // 0 write, 1 read, 2 interrupt
  bit  err_exp = 0;

  always #2 clk = ~clk;

  dma_issuer u_dut (.*);

  task automatic check_eq(input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int lowfree();
    for (int i = 0; i < 16; i++) if (!busy[i]) return i;
    return -1;
  endfunction

  function automatic int cls_of(input logic [2:0] k);
    if (k == 3'd4) return 2;
    if (k[1]) return 1;
    return 0;
  endfunction

  task automatic issue(input logic [2:0] k, input logic [39:0] a, input logic [127:0] d,
                       input logic [15:0] m, input string lbl);
    int id;
    logic [4:0] ep;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; req_data = d; req_mask = m;
    #1;
    check_eq({lbl, " R1 ready"}, req_ready, 1);
    id = lowfree();
    @(negedge clk);
    req_valid = 0;
    check_eq({lbl, " R1 cmd_valid"}, cmd_valid, 1);
    check_eq({lbl, " R1 cmd_code"}, cmd_code, {1'b0, k});
    check_eq({lbl, " R1 cmd_addr"}, cmd_addr, a);
    check_eq({lbl, " R2 R3 cmd_tag"}, cmd_tag, {(k == 3'd3), 4'(id), 11'b0});
    busy[id] = 1; own[id] = cls_of(k);
    @(negedge clk);
    check_eq({lbl, " R1 single cmd"}, cmd_valid, 0);
    if (k <= 3'd1) begin
      ep = {~^d[127:96], ~^d[95:64], ~^d[63:32], ~^d[31:0], ~^m};
      check_eq({lbl, " R8 dat_valid"}, dat_valid, 1);
      check_eq({lbl, " R8 dat_beat"}, dat_beat, d);
      check_eq({lbl, " R8 dat_mask"}, dat_mask, m);
      check_eq({lbl, " R9 dat_par"}, dat_par, ep);
    end else begin
      check_eq({lbl, " R8 no data beat"}, dat_valid, 0);
    end
  endtask

  task automatic send_wack(input int id, input string lbl);
    @(negedge clk);
    wack_valid = 1; wack_id = 4'(id);
    @(negedge clk);
    wack_valid = 0;
    if (busy[id] && own[id] == 0) busy[id] = 0; else err_exp = 1;
    check_eq({lbl, " R6 R10 err_flag"}, err_flag, err_exp);
  endtask

  task automatic send_ret(input logic [1:0] code, input int id, input string lbl);
    @(negedge clk);
    ret_valid = 1; ret_code = code; ret_tag = {1'b0, 4'(id), 11'b0};
    @(negedge clk);
    ret_valid = 0;
    if (busy[id] && own[id] == (code[1] ? 2 : 1)) busy[id] = 0; else err_exp = 1;
    check_eq({lbl, " R7 R10 err_flag"}, err_flag, err_exp);
  endtask

  task automatic probe(input logic [2:0] k, input logic exp, input string lbl);
    @(negedge clk);
    req_valid = 0; req_kind = k;
    #1;
    check_eq(lbl, req_ready, exp);
  endtask

  task automatic t_reset();
    rst = 1; req_valid = 0; req_kind = 0; req_addr = 0; req_data = 0; req_mask = 0;
    wack_valid = 0; wack_id = 0; ret_valid = 0; ret_code = 0; ret_tag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check_eq("R12 ready after reset", req_ready, 1);
    check_eq("R12 cmd_valid after reset", cmd_valid, 0);
    check_eq("R12 dat_valid after reset", dat_valid, 0);
    check_eq("R12 err_flag after reset", err_flag, 0);
  endtask

  task automatic t_encodings();
    issue(3'd0, 40'h12_3456_7890, {4{32'hFFFF_FFFF}}, 16'hFFFF, "full write");
    issue(3'd1, 40'h00_0000_0040, {4{32'hA5A5_0001}}, 16'h00F3, "partial write");
    issue(3'd2, 40'hFF_0000_1000, '0, '0, "read");
    issue(3'd3, 40'h01_2000_0000, '0, '0, "shared read");
    issue(3'd4, 40'h00_0000_0ABC, '0, '0, "interrupt");
  endtask

  task automatic t_retire();
    send_wack(0, "ack write id0");
    send_ret(2'd0, 2, "return read id2");
    send_ret(2'd3, 4, "return interrupt id4");
    issue(3'd2, 40'h55, '0, '0, "R3 reuse lowest");
  endtask

  task automatic t_invalid();
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      req_valid = 1; req_kind = 3'(k);
      #1;
      check_eq("R11 ready low for bad kind", req_ready, 0);
      @(negedge clk);
      req_valid = 0;
      check_eq("R11 no command for bad kind", cmd_valid, 0);
    end
  endtask

  task automatic t_intr_cap();
    for (int i = 0; i < 4; i++) issue(3'd4, 40'(i), '0, '0, "R5 interrupt fill");
    probe(3'd4, 0, "R5 interrupt blocked at cap");
    probe(3'd2, 1, "R5 read still allowed at cap");
    send_ret(2'd2, 2, "R7 retire interrupt id2");
    probe(3'd4, 1, "R5 interrupt allowed after retire");
  endtask

  task automatic t_same_cycle();
    int exp_id;
    exp_id = lowfree();
    @(negedge clk);
    req_valid = 1; req_kind = 3'd2; req_addr = 40'h77;
    ret_valid = 1; ret_code = 2'd1; ret_tag = {1'b0, 4'd0, 11'b0};
    @(negedge clk);
    req_valid = 0; ret_valid = 0;
    check_eq("R3 same-cycle issue id", cmd_tag, {1'b0, 4'(exp_id), 11'b0});
    check_eq("R7 same-cycle retire err", err_flag, 0);
    busy[exp_id] = 1; own[exp_id] = 1; busy[0] = 0;
    issue(3'd0, 40'h80, {4{32'h0000_0001}}, 16'h8001, "R3 retired id reused");
  endtask

  task automatic t_full();
    while (lowfree() >= 0) issue(3'd3, 40'h900, '0, '0, "R4 fill pool");
    probe(3'd0, 0, "R4 write blocked when full");
    probe(3'd2, 0, "R4 read blocked when full");
    send_wack(1, "R6 ack partial write id1");
    probe(3'd0, 1, "R4 ready after retire");
    issue(3'd1, 40'hA0, {4{32'h8000_0000}}, 16'h0001, "R4 refill id1");
  endtask

  task automatic t_error();
    send_wack(2, "R10 ack on read id");
    probe(3'd2, 0, "R10 mismatched ack frees nothing");
    send_ret(2'd0, 2, "R10 proper return after error");
    probe(3'd2, 1, "R10 proper return frees id");
    check_eq("R10 err_flag sticky", err_flag, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin busy[i] = 0; own[i] = 0; end
    t_reset();
    t_encodings();
    t_retire();
    t_invalid();
    t_intr_cap();
    t_same_cycle();
    t_full();
    t_error();
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, all requirements unverified, actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule